// File: doc/BRIEF.md
# Burst Read Address Generator

This block is the synchronous burst front end of a flash read path. After power-on it is asynchronous: the array address simply follows the host address, and the clock and address-valid strobe have no effect on the address path. When software sets the synchronous enable in the configuration register, the block switches to burst operation. A one-clock, active-low address-valid strobe loads the start address into an internal counter. From then on the block generates every following address itself on each clock edge, using the configured burst length and order.

The configuration register is written through a clocked write port. The enable can be cleared again by writing it. A reset command stops a burst in progress but leaves burst mode and the configuration as they were. Only power-on reset returns the block to asynchronous mode.

Top module: `burst_addr_gen`

## Requirements
- R1: After power-on reset (`por_n` low), `sync_mode` and `burst_active` are 0, and `array_addr` equals `start_addr` combinationally.
- R2: While `sync_mode` is 0, `adv_n` pulses and clock edges start no burst: `burst_active` stays 0 and `array_addr` keeps following `start_addr`.
- R3: A configuration write (`cfg_we` high at a clock edge) with `cfg_wdata[0]`=1 sets `sync_mode` after that edge. A write with `cfg_wdata[0]`=0 clears `sync_mode`, ends any burst, and returns `array_addr` to following `start_addr`.
- R4: A `rst_cmd` pulse ends an active burst (`burst_active` low after the edge). It leaves `sync_mode` and the configured length and order unchanged. Only `por_n` clears the enable.
- R5: In synchronous mode, `adv_n` low at a clock edge loads `start_addr`. After that edge, `array_addr` equals the loaded address and `burst_active` is 1.
- R6: At each later edge with `adv_n` high, the block advances the address internally. Changes on `start_addr` during the burst are ignored.
- R7: The length field is `cfg_wdata[2:1]`: 01 selects 4 beats, 10 selects 8 beats, and 00 or 11 selects continuous. A fixed-length burst presents exactly L addresses. At the next edge `burst_active` falls and `array_addr` holds the last address.
- R8: Order bit `cfg_wdata[3]`=0 selects wrap order: beat i is (A & ~(L-1)) | ((A+i) & (L-1)), so the upper bits stay fixed. `cfg_wdata[3]`=1 selects plain linear order: beat i is A+i, which may cross the aligned block.
- R9: A continuous burst increments by one every edge, modulo 2^AW, and never ends by itself.
- R10: An `adv_n` pulse in the middle of a burst restarts it at the new address with a full beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| adv_n | input | 1 | Address-valid strobe, active low |
| start_addr | input | AW | Host start address |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 4 | Configuration: [0] sync enable, [2:1] length, [3] order |
| rst_cmd | input | 1 | Reset-command pulse |
| array_addr | output | AW | Address presented to the array |
| burst_active | output | 1 | Burst in progress |
| sync_mode | output | 1 | 1 when synchronous burst mode is enabled |

## Verification
The hardest cases are the wrap boundaries. Start addresses near the top of an aligned block must fold their low bits back while the upper bits stay fixed, and a continuous burst must roll over the top of the whole address space. The bench reaches both by sweeping every start address of an 8-bit configuration through all four fixed-length modes. It also launches continuous bursts just below the top of the address space. A reset command issued mid-burst is followed by a fresh load with no configuration write. This shows that the length and the enable survived the command.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          adv_n,
  input  logic [AW-1:0] start_addr,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_wdata,
  input  logic          rst_cmd,
  output logic [AW-1:0] array_addr,
  output logic          burst_active,
  output logic          sync_mode
);
  logic          sync_en, nowrap;
  logic [1:0]    len_sel;
  logic [AW-1:0] cnt;
  logic [3:0]    beat;
  logic          act;

  wire           fixed = (len_sel == 2'b01) || (len_sel == 2'b10);
  wire [AW-1:0]  mask  = (len_sel == 2'b10) ? AW'(7) : AW'(3);
  wire [3:0]     last  = (len_sel == 2'b10) ? 4'd8 : 4'd4;
  wire [AW-1:0]  inc   = cnt + 1'b1;
  wire [AW-1:0]  nxt   = (fixed && !nowrap) ? ((cnt & ~mask) | (inc & mask)) : inc;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync_en <= 1'b0;
      nowrap  <= 1'b0;
      len_sel <= 2'b00;
      cnt     <= '0;
      beat    <= '0;
      act     <= 1'b0;
    end else begin
      if (cfg_we) {nowrap, len_sel, sync_en} <= cfg_wdata;
      if (cfg_we && !cfg_wdata[0]) act <= 1'b0;
      else if (rst_cmd) act <= 1'b0;
      else if (sync_en && !adv_n) begin
        cnt  <= start_addr;
        beat <= 4'd1;
        act  <= 1'b1;
      end else if (act) begin
        if (fixed && beat >= last) act <= 1'b0;
        else begin
          cnt  <= nxt;
          beat <= beat + 1'b1;
        end
      end
    end
  end

  assign sync_mode    = sync_en;
  assign burst_active = act;
  assign array_addr   = sync_en ? cnt : start_addr;
endmodule

module burst_addr_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          por_n,
  input logic          adv_n,
  input logic [AW-1:0] start_addr,
  input logic          cfg_we,
  input logic          rst_cmd,
  input logic [AW-1:0] array_addr,
  input logic          burst_active,
  input logic          sync_mode,
  input logic [1:0]    len_sel,
  input logic          nowrap
);
  wire quiet = adv_n && !rst_cmd && !cfg_we;
  wire wrapm = (len_sel == 2'b01 || len_sel == 2'b10) && !nowrap;

  assert_async_idle_R2: assert property (@(posedge clk) disable iff (!por_n)
    !sync_mode |-> !burst_active);

  assert_load_start_R5: assert property (@(posedge clk) disable iff (!por_n)
    sync_mode && !adv_n && !rst_cmd && !cfg_we |=> burst_active && array_addr == $past(start_addr));

  assert_rstcmd_keeps_mode_R4: assert property (@(posedge clk) disable iff (!por_n)
    sync_mode && rst_cmd && !cfg_we |=> sync_mode && !burst_active);

  assert_wrap_upper_R8: assert property (@(posedge clk) disable iff (!por_n)
    burst_active && quiet && wrapm |=> array_addr[AW-1:3] == $past(array_addr[AW-1:3]));

  assert_step_R9: assert property (@(posedge clk) disable iff (!por_n)
    burst_active && quiet && !wrapm |=> !burst_active || array_addr == AW'($past(array_addr) + 1'b1));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .por_n(por_n), .adv_n(adv_n), .start_addr(start_addr),
  .cfg_we(cfg_we), .rst_cmd(rst_cmd), .array_addr(array_addr),
  .burst_active(burst_active), .sync_mode(sync_mode),
  .len_sel(len_sel), .nowrap(nowrap));

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 8;
  logic clk = 0, por_n = 0, adv_n = 1, cfg_we = 0, rst_cmd = 0;
  logic [AW-1:0] start_addr = '0;
  logic [3:0] cfg_wdata = '0;
  logic [AW-1:0] array_addr;
  logic burst_active, sync_mode;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wcfg(input logic [3:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  function automatic int expa(input int a, input int l, input int ord, input int i);
    if (ord == 0) return (a & ~(l - 1)) | ((a + i) & (l - 1));
    return (a + i) % 256;
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1;
    chk(!sync_mode && !burst_active, "R1 reset state", {sync_mode, burst_active}, 0);
    #5 por_n = 1;
    for (int a = 0; a < 256; a += 17) begin
      @(negedge clk); start_addr = a[AW-1:0]; adv_n = 0; #1;
      chk(array_addr == a[AW-1:0], "R1 async passthrough", array_addr, a);
      @(negedge clk);
      chk(!burst_active && array_addr == a[AW-1:0], "R2 adv ignored async", burst_active, 0);
      adv_n = 1;
    end
    // R7 R8 sweep
    for (int m = 0; m < 4; m++) begin
      int l = (m & 1) ? 8 : 4;
      int ord = m >> 1;
      wcfg({ord[0], (l == 8) ? 2'b10 : 2'b01, 1'b1});
      chk(sync_mode, "R3 enable", sync_mode, 1);
      for (int a = 0; a < 256; a++) begin
        @(negedge clk); adv_n = 0; start_addr = a[AW-1:0];
        for (int i = 0; i < l; i++) begin
          @(negedge clk); adv_n = 1; start_addr = ~a[AW-1:0];
          chk(burst_active && array_addr == expa(a, l, ord, i)[AW-1:0],
              (i == 0) ? "R5 load" : (ord == 0 ? "R8 wrap beat R6" : "R8 linear beat R6"),
              array_addr, expa(a, l, ord, i));
        end
        @(negedge clk);
        chk(!burst_active && array_addr == expa(a, l, ord, l - 1)[AW-1:0], "R7 burst end",
            array_addr, expa(a, l, ord, l - 1));
      end
    end
    // R9 continuous, codes 00 and 11
    for (int c = 0; c < 2; c++) begin
      wcfg(c ? 4'b0111 : 4'b0001);
      @(negedge clk); adv_n = 0; start_addr = 8'hFA;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk); adv_n = 1; start_addr = 8'h33;
        chk(burst_active && array_addr == 8'((250 + i) % 256), "R9 continuous", array_addr, (250 + i) % 256);
      end
    end
    // R4 reset command
    @(negedge clk); rst_cmd = 1;
    @(negedge clk); rst_cmd = 0;
    chk(!burst_active && sync_mode, "R4 rstcmd ends burst keeps mode", {sync_mode, burst_active}, 2);
    @(negedge clk); adv_n = 0; start_addr = 8'h10;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); adv_n = 1;
      chk(burst_active && array_addr == 8'(16 + i), "R4 config kept continuous", array_addr, 16 + i);
    end
    // R10 restart
    wcfg(4'b0101);
    @(negedge clk); adv_n = 0; start_addr = 8'h44;
    for (int i = 0; i < 3; i++) begin @(negedge clk); adv_n = 1; end
    adv_n = 0; start_addr = 8'h9D;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); adv_n = 1;
      chk(burst_active && array_addr == expa(157, 8, 0, i)[AW-1:0], "R10 restart", array_addr, expa(157, 8, 0, i));
    end
    @(negedge clk);
    chk(!burst_active, "R10 restart full length", burst_active, 0);
    // R3 disable mid burst
    @(negedge clk); adv_n = 0; start_addr = 8'h20;
    @(negedge clk); adv_n = 1; cfg_we = 1; cfg_wdata = 4'b0100;
    @(negedge clk); cfg_we = 0; start_addr = 8'h5E; #1;
    chk(!sync_mode && !burst_active && array_addr == 8'h5E, "R3 disable", array_addr, 8'h5E);
    // R1 por clears enable
    wcfg(4'b0011);
    @(negedge clk); por_n = 0; #1;
    chk(!sync_mode && !burst_active, "R1 por clears", sync_mode, 0);
    @(negedge clk); por_n = 1; adv_n = 0; start_addr = 8'h77;
    @(negedge clk); adv_n = 1; #1;
    chk(!burst_active && array_addr == 8'h77, "R2 async after por", burst_active, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule